// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Scaled Read-and-Clear

This block holds a 64-bit signed accumulator and updates it once per clock from two 32-bit signed operands. It can add the full-width product of the operands to the accumulator, or subtract that product from it. It can load either 32-bit half of the accumulator from a write-data bus. It can also hand out a scaled 32-bit result while zeroing the accumulator.

The scaled result is bits 59 down to 28 of the accumulator value from before the operation. This equals the accumulator shifted right arithmetically by 28 places and cut to 32 bits. The result appears on a registered output one cycle after the request and stays there until the next read-and-clear. Both accumulator halves are always visible on two outputs, so a surrounding core can read them as ordinary status words. A core issues at most one operation per cycle through a request vector that is qualified by a valid strobe.

Every operation completes in one cycle, and the next operation already sees its result. Back-to-back requests therefore need no interlock.

Top module: `mac_accum_unit`

## Requirements
- R1: After reset, `acc_hi`, `acc_lo` and `rd_data` are all zero.
- R2: With `op_valid` high and only request bit 0 (accumulate) set, the accumulator becomes the old accumulator plus the signed 64-bit product of `opnd_a` and `opnd_b`, one cycle later.
- R3: With `op_valid` high and request bit 1 (subtract) as the highest set bit, the accumulator becomes the old accumulator minus the signed 64-bit product, one cycle later.
- R4: With `op_valid` high and request bit 4 (read-clear) set, `rd_data` becomes bits [59:28] of the accumulator value before the operation, and both accumulator halves become zero, one cycle later.
- R5: With `op_valid` high and request bit 2 (write low) as the highest set bit, `acc_lo` takes `wr_data` and `acc_hi` is unchanged.
- R6: With `op_valid` high and request bit 3 (write high) as the highest set bit, `acc_hi` takes `wr_data` and `acc_lo` is unchanged.
- R7: When several request bits are set in one cycle, only the highest-numbered one takes effect. The order is read-clear (4), write high (3), write low (2), subtract (1), accumulate (0).
- R8: While `op_valid` is low, the request bits have no effect: `acc_hi`, `acc_lo` and `rd_data` hold their values.
- R9: `rd_data` changes only on a read-clear and otherwise keeps the last scaled result.
- R10: Operations issued on consecutive cycles each act on the result of the one before, with no lost update.
- R11: Accumulator arithmetic wraps modulo 2^64, including for products of the most-negative operand value, and no overflow indication exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Qualifies `op_req` for this cycle |
| op_req | input | 5 | Request bits: 0 accumulate, 1 subtract, 2 write low, 3 write high, 4 read-clear |
| opnd_a | input | 32 | Signed multiplicand |
| opnd_b | input | 32 | Signed multiplier |
| wr_data | input | 32 | Data loaded by a half-word write |
| rd_data | output | 32 | Last scaled read-and-clear result |
| acc_hi | output | 32 | Accumulator bits [63:32] |
| acc_lo | output | 32 | Accumulator bits [31:0] |

## Verification
The accumulator halves are outputs, so a wrong product, a wrong sign extension or a lost carry between the halves shows on `acc_hi` or `acc_lo` in the cycle right after the faulty operation. A wrong shift amount or a stale pre-operation value shows on `rd_data` one cycle after a read-clear. A failure to zero the accumulator shows at the same time on the accumulator outputs. Priority and valid-gating faults show the same way: a lower-priority request that leaks through changes a half that should have held, and that half is compared in the very next cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int NUM_OPS   = 5;
    localparam int IDX_ACC   = 0;
    localparam int IDX_SUB   = 1;
    localparam int IDX_WRLO  = 2;
    localparam int IDX_WRHI  = 3;
    localparam int IDX_RDCLR = 4;
endpackage

// File: rtl/mac_product.sv
module mac_product #(
    parameter int OP_W = 32
) (
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [2*OP_W-1:0] prod
);
    localparam int PW = 2 * OP_W;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;

    // Sign-extend both operands to full width; a truncated full-width product is exact.
    assign a_ext = $signed({{OP_W{a[OP_W-1]}}, a});
    assign b_ext = $signed({{OP_W{b[OP_W-1]}}, b});
    assign prod  = PW'(a_ext * b_ext);
endmodule

// File: rtl/mac_grant.sv
module mac_grant #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // Highest-numbered request wins.
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == N - 1) begin : g_top
            assign grant[i] = req[i];
        end else begin : g_low
            assign grant[i] = req[i] & ~(|req[N-1:i+1]);
        end
    end
endmodule

// File: rtl/mac_scaler.sv
module mac_scaler #(
    parameter int ACC_W = 64,
    parameter int OUT_W = 32,
    parameter int SHIFT = 28
) (
    input  logic [ACC_W-1:0] acc,
    output logic [OUT_W-1:0] scaled
);
    logic signed [ACC_W-1:0] shifted;

    assign shifted = $signed(acc) >>> SHIFT;
    assign scaled  = OUT_W'(shifted);
endmodule

// File: rtl/mac_accum_unit.sv
module mac_accum_unit #(
    parameter int OP_W     = 32,
    parameter int RD_SHIFT = 28
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [4:0]      op_req,
    input  logic [OP_W-1:0] opnd_a,
    input  logic [OP_W-1:0] opnd_b,
    input  logic [OP_W-1:0] wr_data,
    output logic [OP_W-1:0] rd_data,
    output logic [OP_W-1:0] acc_hi,
    output logic [OP_W-1:0] acc_lo
);
    import mac_pkg::*;

    localparam int ACC_W = 2 * OP_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [OP_W-1:0]  rd;
    } mac_state_t;

    mac_state_t           st_d;
    mac_state_t           st_q;
    logic [ACC_W-1:0]     prod;
    logic [OP_W-1:0]      scaled;
    logic [NUM_OPS-1:0]   grant;

    mac_product #(.OP_W(OP_W)) u_prod (
        .a    (opnd_a),
        .b    (opnd_b),
        .prod (prod)
    );

    mac_grant #(.N(NUM_OPS)) u_grant (
        .req   (op_req),
        .grant (grant)
    );

    mac_scaler #(.ACC_W(ACC_W), .OUT_W(OP_W), .SHIFT(RD_SHIFT)) u_scale (
        .acc    (st_q.acc),
        .scaled (scaled)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            if (grant[IDX_RDCLR]) begin
                st_d.rd  = scaled;
                st_d.acc = '0;
            end else if (grant[IDX_WRHI]) begin
                st_d.acc = {wr_data, st_q.acc[OP_W-1:0]};
            end else if (grant[IDX_WRLO]) begin
                st_d.acc = {st_q.acc[ACC_W-1:OP_W], wr_data};
            end else if (grant[IDX_SUB]) begin
                st_d.acc = st_q.acc - prod;
            end else if (grant[IDX_ACC]) begin
                st_d.acc = st_q.acc + prod;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd;
    assign acc_hi  = st_q.acc[ACC_W-1:OP_W];
    assign acc_lo  = st_q.acc[OP_W-1:0];
endmodule

// File: rtl/mac_accum_chk.sv
module mac_accum_chk #(
    parameter int OP_W     = 32,
    parameter int RD_SHIFT = 28
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [4:0]      op_req,
    input logic [OP_W-1:0] wr_data,
    input logic [OP_W-1:0] rd_data,
    input logic [OP_W-1:0] acc_hi,
    input logic [OP_W-1:0] acc_lo
);
    import mac_pkg::*;

    logic [2*OP_W-1:0] acc_cat;
    logic [OP_W-1:0]   rd_expect;

    assign acc_cat   = {acc_hi, acc_lo};
    assign rd_expect = OP_W'($signed(acc_cat) >>> RD_SHIFT);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(acc_hi) && $stable(acc_lo) && $stable(rd_data));

    // R4
    rdclr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_req[IDX_RDCLR] |=> acc_hi == '0 && acc_lo == '0);

    // R4
    rdclr_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_req[IDX_RDCLR] |=> rd_data == $past(rd_expect));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_req[IDX_RDCLR]) |=> $stable(rd_data));

    // R6
    wrhi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_req[IDX_WRHI] && !op_req[IDX_RDCLR]
        |=> acc_hi == $past(wr_data) && $stable(acc_lo));

    // R5
    wrlo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_req[IDX_WRLO] && !op_req[IDX_WRHI] && !op_req[IDX_RDCLR]
        |=> acc_lo == $past(wr_data) && $stable(acc_hi));
endmodule

bind mac_accum_unit mac_accum_chk #(.OP_W(OP_W), .RD_SHIFT(RD_SHIFT)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_req   (op_req),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .acc_hi   (acc_hi),
    .acc_lo   (acc_lo)
);

// File: tb/mac_accum_unit_tb_top.sv
module mac_accum_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_req = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] acc_hi;
    logic [31:0] acc_lo;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    longint      m_acc = 0;
    logic [31:0] m_rd  = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mac_accum_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_req   (op_req),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .acc_hi   (acc_hi),
        .acc_lo   (acc_lo)
    );

    task automatic check32(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check32(tag, "acc_hi",  acc_hi,  m_acc[63:32]);
        check32(tag, "acc_lo",  acc_lo,  m_acc[31:0]);
        check32(tag, "rd_data", rd_data, m_rd);
    endtask

    // Behavioural reference: one operation per cycle, highest request bit wins.
    task automatic model_update(input bit v, input logic [4:0] rq,
                                input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] wd);
        longint pa = longint'($signed(a));
        longint pb = longint'($signed(b));
        longint shifted;
        if (!v) return;
        if (rq[4]) begin
            shifted = m_acc >>> 28;
            m_rd    = shifted[31:0];
            m_acc   = 0;
        end else if (rq[3]) begin
            m_acc[63:32] = wd;
        end else if (rq[2]) begin
            m_acc[31:0] = wd;
        end else if (rq[1]) begin
            m_acc = m_acc - pa * pb;
        end else if (rq[0]) begin
            m_acc = m_acc + pa * pb;
        end
    endtask

    // Inputs are driven at the falling edge; outputs are compared at the next falling edge.
    task automatic step(input string tag, input bit v, input logic [4:0] rq,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] wd);
        op_valid = v;
        op_req   = rq;
        opnd_a   = a;
        opnd_b   = b;
        wr_data  = wd;
        @(posedge clk);
        model_update(v, rq, a, b, wd);
        @(negedge clk);
        compare_all(tag);
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 7))
            0:       return 32'h8000_0000;
            1:       return 32'h7FFF_FFFF;
            2:       return 32'hFFFF_FFFF;
            3:       return 32'h0000_0001;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        op_req = 5'b11111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        op_req = '0;
        // R1: reset state
        compare_all("R1");

        // R2: accumulate small and mixed-sign products
        step("R2", 1, 5'b00001, 32'd7, 32'd6, 32'h0);
        step("R2", 1, 5'b00001, 32'hFFFF_FFFD, 32'd5, 32'h0);
        // R11: most-negative squared, then push past the top
        step("R11", 1, 5'b00001, 32'h8000_0000, 32'h8000_0000, 32'h0);
        step("R11", 1, 5'b00001, 32'h8000_0000, 32'h8000_0000, 32'h0);
        // R3: subtract
        step("R3", 1, 5'b00010, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0);
        // R4: read-clear of a value with high bits set
        step("R4", 1, 5'b10000, 32'h0, 32'h0, 32'h0);
        step("R4", 1, 5'b10000, 32'h0, 32'h0, 32'h0);
        // R6, R5: half-word loads
        step("R6", 1, 5'b01000, 32'h0, 32'h0, 32'hF123_4567);
        step("R5", 1, 5'b00100, 32'h0, 32'h0, 32'h89AB_CDEF);
        // R4: negative accumulator scaled with sign
        step("R4", 1, 5'b10000, 32'h0, 32'h0, 32'h0);
        // R11: wrap from the largest positive value
        step("R11", 1, 5'b01000, 32'h0, 32'h0, 32'h7FFF_FFFF);
        step("R11", 1, 5'b00100, 32'h0, 32'h0, 32'hFFFF_FFFF);
        step("R11", 1, 5'b00001, 32'd1, 32'd1, 32'h0);
        // R8: requests ignored without valid
        step("R8", 0, 5'b11111, 32'd3, 32'd3, 32'h1111_1111);
        step("R8", 0, 5'b10000, 32'd3, 32'd3, 32'h1111_1111);
        // R7: priority combinations
        step("R7", 1, 5'b11111, 32'd9, 32'd9, 32'h2222_2222);
        step("R7", 1, 5'b01111, 32'd9, 32'd9, 32'h3333_3333);
        step("R7", 1, 5'b00111, 32'd9, 32'd9, 32'h4444_4444);
        step("R7", 1, 5'b00011, 32'd9, 32'd9, 32'h5555_5555);
        // R9: rd_data holds across non-read operations
        step("R9", 1, 5'b00001, 32'd100, 32'd100, 32'h0);
        // R10: back-to-back random operations
        for (int i = 0; i < N_RANDOM; i++) begin
            step("R10", ($urandom_range(0, 9) != 0), 5'($urandom_range(0, 31) & ($urandom_range(0,3) == 0 ? 5'b11111 : 5'b00011)),
                 pick(), pick(), $urandom());
        end
        step("R4", 1, 5'b10000, 32'h0, 32'h0, 32'h0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule